// File: doc/BRIEF.md
# Audio Serial Port Clock Master

This block produces the bit clock and the frame (word-select) clock of a stereo serial audio port when that port is the clock master. Its only timing source is an audio master clock. A two-bit speed field (normal, double or quad rate) and a two-bit ratio field together select how many master-clock periods make one sample period. From that ratio the block derives a bit clock at 64 times the sample rate and a frame clock at the sample rate. It also drives a flag that is high only while both clocks are stable and trustworthy.

All logic runs on one free-running reference clock. The master clock enters as an asynchronous level, passes through a synchronizer and is edge-detected, so the reference clock must be comfortably faster than twice the master clock. An activity watchdog holds the block idle from reset until master-clock edges arrive, and again whenever they stop. A power-down pin forces the same idle state. When the configuration changes, the flag drops at once. The new divide ratio takes over only at the next frame boundary, so no runt or stretched pulse is sent mid-frame.

No data path exists here, so no valid/ready interface is used. Every pin is a plain control or status level.

Top module: `audclk_master_gen`

## Requirements
- R1: Speed code 00 is normal, 01 is double and 10 is quad. Reserved code 11 behaves exactly like normal, so speed 11 with ratio 01 gives 384 master clocks per frame and a bit clock of master/6.
- R2: At normal speed, ratio codes 00, 01, 10 and 11 give 256, 384, 512 and 256 master clocks per sample. The bit clock is then master divided by 4, 6, 8 and 4.
- R3: At double speed, ratio codes 00, 01, 10 and 11 give 128, 192, 256 and 256 master clocks per sample. The bit clock is then master divided by 2, 3, 4 and 4.
- R4: At quad speed, every ratio code gives 128 master clocks per sample, so the bit clock is master divided by 2.
- R5: The bit clock period is D master-clock periods, where D is the ratio divided by 64. The bit clock is high for floor(D/2) of those periods. It changes only after a master-clock rising edge.
- R6: Each frame-clock period holds 64 bit-clock periods. The frame clock is low for 32 of them (left) and high for 32 (right). It changes only together with a falling bit-clock edge.
- R7: While the power-down input is 1, the bit clock, the frame clock and the valid flag are all held at 0, starting one reference cycle after it is sampled.
- R8: After reset, the outputs stay at 0 until a master-clock edge is seen. If no master-clock edge occurs for 16 reference cycles, the block returns to that idle state. It restarts by itself when edges resume.
- R9: When the decoded divide ratio differs from the one in use, the valid flag is 0 from the next reference cycle. The new ratio is loaded only at a frame boundary. A field change that decodes to the same ratio leaves the flag at 1.
- R10: The valid flag rises only at the end of a complete frame that ran entirely under unchanged settings. On a fresh start, this is the end of the first frame, 64·D master-clock periods after the first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mclk_i | input | 1 | Audio master clock, asynchronous level |
| pd_i | input | 1 | Power-down, 1 holds all outputs idle |
| speed_i | input | 2 | Speed mode: 00 normal, 01 double, 10 quad, 11 as normal |
| ratio_i | input | 2 | Master-clock-to-sample ratio select |
| bick_o | output | 1 | Bit clock at 64 times the sample rate |
| lrck_o | output | 1 | Frame clock, 0 = left, 1 = right |
| valid_o | output | 1 | Clocks are stable under the current settings |

## Verification
The block is driven through every speed code against several ratio codes. The chosen sequence mixes changes that alter the decoded divisor with changes that do not. Even divisors 2, 4, 6 and 8 are used alongside the odd divisor 3, so the bench can tell period errors from duty errors, and a wrong table entry shows up as a wrong measured period. Power-down and a stopped master clock are each applied while the block is running. The bench then looks for forced idle outputs, for the 16-cycle timeout versus a shorter gap, and for clean recovery. Valid-flag timing from a cold start separates the end of the first full frame from any earlier rise.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
  localparam int unsigned DIV_W      = 4;

  // Bit-clock divisor = (master clocks per sample) / FRAME_BITS
  function automatic logic [DIV_W-1:0] bick_div(input speed_e spd, input logic [1:0] sel);
    logic [DIV_W-1:0] d;
    case (spd)
      SPD_DOUBLE: begin
        case (sel)
          2'b00:   d = DIV_W'(2);
          2'b01:   d = DIV_W'(3);
          default: d = DIV_W'(4);
        endcase
      end
      SPD_QUAD: d = DIV_W'(2);
      default: begin
        case (sel)
          2'b01:   d = DIV_W'(6);
          2'b10:   d = DIV_W'(8);
          default: d = DIV_W'(4);
        endcase
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/audclk_cfg_decode.sv
module audclk_cfg_decode
  import audclk_pkg::*;
(
  input  logic [1:0]       speed_i,
  input  logic [1:0]       ratio_i,
  output logic [DIV_W-1:0] div_o
);

  speed_e spd;

  always_comb begin
    spd   = speed_e'(speed_i);
    div_o = bick_div(spd, ratio_i);
  end

endmodule

// File: rtl/audclk_mclk_watch.sv
module audclk_mclk_watch #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TIMEOUT     = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mclk_i,
  output logic mclk_rise_o,
  output logic alive_o
);

  localparam int unsigned CNT_W = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       idle_q;
  logic                   alive_q;
  logic                   any_edge;

  always_comb begin
    any_edge    = sync_q[SYNC_STAGES-1] ^ prev_q;
    mclk_rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
    alive_o     = alive_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      idle_q  <= '0;
      alive_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], mclk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (any_edge) begin
        idle_q  <= '0;
        alive_q <= 1'b1;
      end else if (idle_q == CNT_W'(TIMEOUT - 1)) begin
        alive_q <= 1'b0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  // R8
  alive_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alive_q) |-> $past(any_edge));

  // R8
  alive_drop_after_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(alive_q) |-> !$past(any_edge));

endmodule

// File: rtl/audclk_divider.sv
module audclk_divider
  import audclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             mclk_rise_i,
  input  logic [DIV_W-1:0] div_req_i,
  output logic             bick_o,
  output logic             lrck_o,
  output logic             valid_o
);

  logic [DIV_W-1:0] div_act_q;
  logic [DIV_W-1:0] pc_q, pc_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             bick_q, lrck_q, valid_q, clean_q;
  logic             mismatch, pc_wrap, frame_wrap;

  always_comb begin
    mismatch   = (div_req_i != div_act_q);
    pc_wrap    = mclk_rise_i && (pc_q == div_act_q - 1'b1);
    frame_wrap = pc_wrap && (bit_q == BIT_W'(FRAME_BITS - 1));
    pc_n       = pc_wrap ? '0 : pc_q + 1'b1;
    bit_n      = bit_q + 1'b1;
    bick_o     = bick_q;
    lrck_o     = lrck_q;
    valid_o    = valid_q;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_act_q <= DIV_W'(4);
      pc_q      <= '0;
      bit_q     <= '0;
      bick_q    <= 1'b0;
      lrck_q    <= 1'b0;
      valid_q   <= 1'b0;
      clean_q   <= 1'b1;
    end else if (!run_i) begin
      div_act_q <= div_req_i;
      pc_q      <= '0;
      bit_q     <= '0;
      bick_q    <= 1'b0;
      lrck_q    <= 1'b0;
      valid_q   <= 1'b0;
      clean_q   <= 1'b1;
    end else begin
      if (mismatch) begin
        valid_q <= 1'b0;
        clean_q <= 1'b0;
      end
      if (mclk_rise_i) begin
        pc_q   <= pc_n;
        bick_q <= (pc_n >= div_act_q - (div_act_q >> 1));
        if (pc_wrap) begin
          bit_q  <= bit_n;
          lrck_q <= bit_n[BIT_W-1];
        end
        if (frame_wrap) begin
          clean_q <= 1'b1;
          if (mismatch) begin
            div_act_q <= div_req_i;
            valid_q   <= 1'b0;
          end else begin
            valid_q <= clean_q;
          end
        end
      end
    end
  end

  // R5
  bick_on_mclk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bick_q) |-> $past(mclk_rise_i));

  // R6
  lrck_on_bick_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(lrck_q)) |-> $fell(bick_q));

  // R9
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch |=> !valid_q);

  // R9
  reload_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$stable(div_act_q)) |-> $past(frame_wrap));

  // R10
  valid_at_frame_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(frame_wrap));

endmodule

// File: rtl/audclk_master_gen.sv
module audclk_master_gen
  import audclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WDOG_CYCLES = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mclk_i,
  input  logic       pd_i,
  input  logic [1:0] speed_i,
  input  logic [1:0] ratio_i,
  output logic       bick_o,
  output logic       lrck_o,
  output logic       valid_o
);

  logic [DIV_W-1:0] div_req;
  logic             mclk_rise, alive, run;

  audclk_cfg_decode i_decode (
    .speed_i (speed_i),
    .ratio_i (ratio_i),
    .div_o   (div_req)
  );

  audclk_mclk_watch #(
    .SYNC_STAGES (SYNC_STAGES),
    .TIMEOUT     (WDOG_CYCLES)
  ) i_watch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mclk_i      (mclk_i),
    .mclk_rise_o (mclk_rise),
    .alive_o     (alive)
  );

  always_comb run = alive && !pd_i;

  audclk_divider i_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .mclk_rise_i (mclk_rise),
    .div_req_i   (div_req),
    .bick_o      (bick_o),
    .lrck_o      (lrck_o),
    .valid_o     (valid_o)
  );

  // R7
  pd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |=> (!bick_o && !lrck_o && !valid_o));

  // R8
  dead_mclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alive |=> (!bick_o && !valid_o));

endmodule

// File: tb/test_audclk_master_gen.sv
module test_audclk_master_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk = 1'b0;
  logic mclk_en = 1'b0;
  logic pd = 1'b0;
  logic [1:0] speed = 2'b00;
  logic [1:0] ratio = 2'b00;
  logic bick, lrck, valid;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  localparam int MP = 4; // master-clock period in reference cycles

  typedef struct { int d; string tag; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  initial forever begin
    repeat (MP/2) @(negedge clk);
    if (mclk_en) mclk = ~mclk;
  end

  audclk_master_gen i_audclk_master_gen (
    .clk_i (clk), .rst_ni (rst_n), .mclk_i (mclk), .pd_i (pd),
    .speed_i (speed), .ratio_i (ratio),
    .bick_o (bick), .lrck_o (lrck), .valid_o (valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_level(input int which, input logic lvl, output int c);
    c = 0;
    while (((which == 0) ? bick : lrck) != lvl && c < 20000) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic wait_valid(output int c);
    c = 0;
    while (!valid && c < 20000) begin
      @(negedge clk);
      c++;
    end
  endtask

  // driver: apply settings, push the expected divisor
  task automatic apply(input logic [1:0] s, input logic [1:0] r, input int d,
                       input bit changes, input string tag);
    speed = s;
    ratio = r;
    sb_q.push_back('{d, tag});
    repeat (2) @(negedge clk);
    chk({"R9 valid after setting change ", tag}, int'(valid), changes ? 0 : 1);
  endtask

  // monitor: pop the expected item and measure the running clocks
  task automatic check_next();
    exp_t e;
    int c, hi, lo, rises;
    logic pb;
    e = sb_q.pop_front();
    wait_valid(c);
    chk({"R10 valid reached ", e.tag}, int'(valid), 1);
    wait_level(0, 1'b0, c);
    wait_level(0, 1'b1, c);
    wait_level(0, 1'b0, hi);
    wait_level(0, 1'b1, lo);
    chk({e.tag, " R5 bick high time"}, hi, (e.d / 2) * MP);
    chk({e.tag, " bick period (R1/R2/R3/R4)"}, hi + lo, e.d * MP);
    wait_level(1, 1'b0, c);
    wait_level(1, 1'b1, c);
    chk({e.tag, " R6 bick low at lrck rise"}, int'(bick), 0);
    c = 0;
    rises = 0;
    pb = bick;
    while (lrck && c < 20000) begin
      @(negedge clk);
      c++;
      if (bick && !pb) rises++;
      pb = bick;
    end
    chk({e.tag, " R6 right half length"}, c, 32 * e.d * MP);
    chk({e.tag, " R6 bick count per half"}, rises, 32);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset bick", int'(bick), 0);
    chk("R8 reset lrck", int'(lrck), 0);
    chk("R8 reset valid", int'(valid), 0);
    repeat (50) @(negedge clk);
    chk("R8 idle without mclk", int'(bick | lrck | valid), 0);

    // cold start at normal speed, ratio 256
    mclk_en = 1'b1;
    repeat (64 * 4 * MP - 12) @(negedge clk);
    chk("R10 no valid before first frame ends", int'(valid), 0);
    repeat (28) @(negedge clk);
    chk("R10 valid after first frame", int'(valid), 1);
    sb_q.push_back('{4, "N00"});
    check_next();

    apply(2'b00, 2'b01, 6, 1, "N01"); check_next();
    apply(2'b00, 2'b10, 8, 1, "N10"); check_next();
    apply(2'b00, 2'b11, 4, 1, "N11"); check_next();
    apply(2'b01, 2'b00, 2, 1, "D00"); check_next();
    apply(2'b01, 2'b01, 3, 1, "D01"); check_next();
    apply(2'b01, 2'b10, 4, 1, "D10"); check_next();
    apply(2'b01, 2'b11, 4, 0, "D11"); check_next();
    apply(2'b10, 2'b00, 2, 1, "Q00"); check_next();
    apply(2'b10, 2'b10, 2, 0, "Q10"); check_next();
    apply(2'b11, 2'b01, 6, 1, "R1 reserved speed"); check_next();

    // power-down while running
    pd = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 pd bick", int'(bick), 0);
    chk("R7 pd lrck", int'(lrck), 0);
    chk("R7 pd valid", int'(valid), 0);
    c = 0;
    repeat (60) begin
      @(negedge clk);
      c += int'(bick | lrck | valid);
    end
    chk("R7 pd held idle", c, 0);
    pd = 1'b0;
    sb_q.push_back('{6, "R7 restart"});
    check_next();

    // stop master clock
    mclk_en = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 short gap keeps valid", int'(valid), 1);
    repeat (32) @(negedge clk);
    chk("R8 watchdog idle", int'(bick | lrck | valid), 0);
    mclk_en = 1'b1;
    sb_q.push_back('{6, "R8 recovery"});
    check_next();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule